// File: doc/BRIEF.md
# DMA Channel Interrupt Register Bank

This block holds the interrupt-related registers of a single DMA channel. The data mover reports events as one-cycle pulses: transfer done, bus errors, descriptor errors and descriptor completion. The bank stores each event in a sticky status bit. Software sees these bits through a simple 32-bit register port with address, read strobe, write strobe, write data and combinational read data. Status bits are cleared by writing ones. A mask can only be changed through two write-only ports: one unmasks sources and the other masks them. A single level interrupt follows the unmasked status.

The bank also keeps three counters. Two are completion-accounting counters, one for the source side and one for the destination side. Each counts the increment pulses it receives, saturates at its maximum, and clears when software reads it. A third counter totals the bytes moved. When the byte total wraps past its width it raises an overflow status bit. Any read or write to an offset that is not in the map raises an invalid-access status bit.

Top module: `dma_irq_regbank`

## Requirements
- R1: After reset, status reads 0, the mask reads 0xFFF, all three counters read 0 and `irq` is low.
- R2: A pulse on an event input sets its status bit (offset 0x100) at the next clock edge, and the bit stays set. The bit positions are: 10 transfer done, 9 write-data error, 8 read-data error, 7 destination-descriptor error, 6 source-descriptor error, 2 destination descriptor done. Bits 1 and 11 always read 0.
- R3: Writing to 0x100 clears each status bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: If an event and a write-one clear hit the same status bit in the same cycle, the bit stays set.
- R5: A mask bit of 1 masks its source. Writing ones to 0x108 clears those mask bits, and writing ones to 0x10C sets them. The mask reads at 0x104, and writes to 0x104 leave it unchanged.
- R6: `irq` is high exactly while status AND NOT mask is nonzero, with no added cycle of delay.
- R7: The source accounting counter (0x190) and the destination accounting counter (0x194) each add one per increment pulse. A read returns the current value and clears the counter. An increment in the same cycle as the read leaves the counter at 1.
- R8: A counter holds at 2^ACCT_W-1. An increment that arrives while the counter is saturated and not being read sets status bit 4 for the source counter or bit 5 for the destination counter.
- R9: The byte counter (0x188) adds `beat_bytes` on each cycle with `beat_vld` high. A write to 0x188 loads the write data, so writing 0 restarts the count. A write takes priority over a beat in the same cycle.
- R10: When an addition carries out of BYTE_W bits, the counter keeps the sum modulo 2^BYTE_W and status bit 3 is set.
- R11: A read or write to any offset other than 0x100, 0x104, 0x108, 0x10C, 0x188, 0x190 and 0x194 sets status bit 0 and reads as 0. Reads of 0x108 and 0x10C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_rd | input | 1 | Read strobe; counters that clear on read clear at this edge |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data; valid in the cycle `reg_rd` is high, 0 otherwise |
| ev_xfer_done | input | 1 | Transfer finished pulse |
| ev_wdata_err | input | 1 | Write-data bus error pulse |
| ev_rdata_err | input | 1 | Read-data bus error pulse |
| ev_ddesc_err | input | 1 | Destination-descriptor fetch error pulse |
| ev_sdesc_err | input | 1 | Source-descriptor fetch error pulse |
| ev_ddesc_done | input | 1 | Destination descriptor finished pulse |
| src_acct_inc | input | 1 | Source accounting increment |
| dst_acct_inc | input | 1 | Destination accounting increment (a descriptor that requests a completion interrupt has finished) |
| beat_vld | input | 1 | A beat of data has been moved |
| beat_bytes | input | BEAT_W | Byte count of that beat |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the bank with ACCT_W=3, BYTE_W=8 and BEAT_W=6. With these values the accounting counters saturate after seven increments, and the byte counter wraps after a handful of beats. Saturation, its error bits and byte overflow therefore occur many times in a few thousand random cycles, not just once in a directed test. The random mix also produces events that coincide with clears, reads that coincide with increments, and writes that coincide with beats. These collisions exercise the priority rules.

// File: rtl/dma_irq_regbank.sv
module dma_irq_regbank #(
  parameter int ADDR_W = 12,
  parameter int ACCT_W = 8,
  parameter int BYTE_W = 32,
  parameter int BEAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_xfer_done,
  input  logic              ev_wdata_err,
  input  logic              ev_rdata_err,
  input  logic              ev_ddesc_err,
  input  logic              ev_sdesc_err,
  input  logic              ev_ddesc_done,
  input  logic              src_acct_inc,
  input  logic              dst_acct_inc,
  input  logic              beat_vld,
  input  logic [BEAT_W-1:0] beat_bytes,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h104);
  localparam logic [ADDR_W-1:0] A_UNM  = ADDR_W'('h108);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'('h10C);
  localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'('h188);
  localparam logic [ADDR_W-1:0] A_SACC = ADDR_W'('h190);
  localparam logic [ADDR_W-1:0] A_DACC = ADDR_W'('h194);
  localparam logic [ACCT_W-1:0] ACC_ONE = ACCT_W'(1);

  logic [11:0]       stat_q, mask_q, st_set, st_clr;
  logic [ACCT_W-1:0] sacc_q, dacc_q;
  logic [BYTE_W-1:0] bytes_q;
  logic [BYTE_W:0]   bsum;

  wire h_stat = reg_addr == A_STAT;
  wire h_mask = reg_addr == A_MASK;
  wire h_unm  = reg_addr == A_UNM;
  wire h_msk  = reg_addr == A_MSK;
  wire h_byte = reg_addr == A_BYTE;
  wire h_sacc = reg_addr == A_SACC;
  wire h_dacc = reg_addr == A_DACC;
  wire mapped = h_stat | h_mask | h_unm | h_msk | h_byte | h_sacc | h_dacc;
  wire bad    = (reg_rd | reg_wr) & ~mapped;

  wire sacc_rd   = reg_rd & h_sacc;
  wire dacc_rd   = reg_rd & h_dacc;
  wire sacc_full = &sacc_q;
  wire dacc_full = &dacc_q;
  wire sacc_err  = src_acct_inc & sacc_full & ~sacc_rd;
  wire dacc_err  = dst_acct_inc & dacc_full & ~dacc_rd;

  wire bwr = reg_wr & h_byte;
  assign bsum = {1'b0, bytes_q} + {{(BYTE_W + 1 - BEAT_W){1'b0}}, beat_bytes};
  wire b_ovf = beat_vld & ~bwr & bsum[BYTE_W];

  assign st_set = {1'b0, ev_xfer_done, ev_wdata_err, ev_rdata_err, ev_ddesc_err,
                   ev_sdesc_err, dacc_err, sacc_err, b_ovf, ev_ddesc_done, 1'b0, bad};
  assign st_clr = (reg_wr & h_stat) ? reg_wdata[11:0] : 12'h000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '1;
      sacc_q  <= '0;
      dacc_q  <= '0;
      bytes_q <= '0;
    end else begin
      stat_q <= (stat_q & ~st_clr) | st_set;
      if (reg_wr & h_unm)      mask_q <= mask_q & ~reg_wdata[11:0];
      else if (reg_wr & h_msk) mask_q <= mask_q | reg_wdata[11:0];
      if (sacc_rd)                         sacc_q <= src_acct_inc ? ACC_ONE : '0;
      else if (src_acct_inc & ~sacc_full)  sacc_q <= sacc_q + ACC_ONE;
      if (dacc_rd)                         dacc_q <= dst_acct_inc ? ACC_ONE : '0;
      else if (dst_acct_inc & ~dacc_full)  dacc_q <= dacc_q + ACC_ONE;
      if (bwr)           bytes_q <= reg_wdata[BYTE_W-1:0];
      else if (beat_vld) bytes_q <= bsum[BYTE_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (h_stat)      reg_rdata = 32'(stat_q);
      else if (h_mask) reg_rdata = 32'(mask_q);
      else if (h_byte) reg_rdata = 32'(bytes_q);
      else if (h_sacc) reg_rdata = 32'(sacc_q);
      else if (h_dacc) reg_rdata = 32'(dacc_q);
    end
  end

  assign irq = |(stat_q & ~mask_q);

  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xfer_done |=> stat_q[10]);
  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && h_stat && reg_wdata[9] && !ev_wdata_err) |=> !stat_q[9]);
  // R5
  unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && h_unm) |=> ((mask_q & $past(reg_wdata[11:0])) == 12'h000));
  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != 12'h000));
  // R7
  acct_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sacc_rd && !src_acct_inc) |=> (sacc_q == '0));
  // R8
  acct_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_acct_inc && dacc_full && !dacc_rd) |=> (stat_q[5] && dacc_full));
  // R11
  bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> stat_q[0]);
endmodule

// File: tb/test_dma_irq_regbank.sv
module test_dma_irq_regbank;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int ACCT_W = 3;
  localparam int BYTE_W = 8;
  localparam int BEAT_W = 6;

  logic clk = 0, rst_n = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic reg_rd = 0, reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ev_xfer_done = 0, ev_wdata_err = 0, ev_rdata_err = 0, ev_ddesc_err = 0;
  logic ev_sdesc_err = 0, ev_ddesc_done = 0, src_acct_inc = 0, dst_acct_inc = 0;
  logic beat_vld = 0;
  logic [BEAT_W-1:0] beat_bytes = '0;
  logic irq;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [11:0] m_st = '0, m_mask = 12'hFFF;
  logic [ACCT_W-1:0] m_src = '0, m_dst = '0;
  logic [BYTE_W-1:0] m_bytes = '0;

  dma_irq_regbank #(.ADDR_W(ADDR_W), .ACCT_W(ACCT_W), .BYTE_W(BYTE_W), .BEAT_W(BEAT_W))
  i_dma_irq_regbank (
    .clk, .rst_n, .reg_addr, .reg_rd, .reg_wr, .reg_wdata, .reg_rdata,
    .ev_xfer_done, .ev_wdata_err, .ev_rdata_err, .ev_ddesc_err, .ev_sdesc_err,
    .ev_ddesc_done, .src_acct_inc, .dst_acct_inc, .beat_vld, .beat_bytes, .irq);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_mapped(input logic [ADDR_W-1:0] a);
    return a == 'h100 || a == 'h104 || a == 'h108 || a == 'h10C ||
           a == 'h188 || a == 'h190 || a == 'h194;
  endfunction

  function automatic logic [31:0] model_rd(input logic [ADDR_W-1:0] a);
    case (a)
      'h100: return 32'(m_st);
      'h104: return 32'(m_mask);
      'h188: return 32'(m_bytes);
      'h190: return 32'(m_src);
      'h194: return 32'(m_dst);
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    logic [11:0] set, clr;
    logic [BYTE_W:0] sum;
    logic s_rd, d_rd, smax, dmax;
    s_rd = reg_rd && reg_addr == 'h190;
    d_rd = reg_rd && reg_addr == 'h194;
    smax = m_src == {ACCT_W{1'b1}};
    dmax = m_dst == {ACCT_W{1'b1}};
    sum = {1'b0, m_bytes} + (BYTE_W+1)'(beat_bytes);
    set = '0;
    set[10] = ev_xfer_done; set[9] = ev_wdata_err; set[8] = ev_rdata_err;
    set[7] = ev_ddesc_err; set[6] = ev_sdesc_err; set[2] = ev_ddesc_done;
    set[5] = dst_acct_inc && dmax && !d_rd;
    set[4] = src_acct_inc && smax && !s_rd;
    set[3] = beat_vld && !(reg_wr && reg_addr == 'h188) && sum[BYTE_W];
    set[0] = (reg_rd || reg_wr) && !is_mapped(reg_addr);
    clr = (reg_wr && reg_addr == 'h100) ? reg_wdata[11:0] : 12'h0;
    m_st = ((m_st & ~clr) | set) & 12'h7FD;
    if (reg_wr && reg_addr == 'h108) m_mask = m_mask & ~reg_wdata[11:0];
    if (reg_wr && reg_addr == 'h10C) m_mask = m_mask | reg_wdata[11:0];
    if (s_rd) m_src = src_acct_inc ? 1 : 0;
    else if (src_acct_inc && !smax) m_src = m_src + 1;
    if (d_rd) m_dst = dst_acct_inc ? 1 : 0;
    else if (dst_acct_inc && !dmax) m_dst = m_dst + 1;
    if (reg_wr && reg_addr == 'h188) m_bytes = reg_wdata[BYTE_W-1:0];
    else if (beat_vld) m_bytes = sum[BYTE_W-1:0];
  endtask

  task automatic idle();
    reg_rd = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    ev_xfer_done = 0; ev_wdata_err = 0; ev_rdata_err = 0; ev_ddesc_err = 0;
    ev_sdesc_err = 0; ev_ddesc_done = 0; src_acct_inc = 0; dst_acct_inc = 0;
    beat_vld = 0; beat_bytes = '0;
  endtask

  // Inputs are driven just after a falling edge; checks run 1 time unit later.
  task automatic cyc();
    #1;
    chk(32'(irq), 32'(|(m_st & ~m_mask)), "R6 irq");
    if (reg_rd) chk(reg_rdata, model_rd(reg_addr), "R2/R5/R7/R9/R11 rdata vs model");
    model_step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rdx(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1; reg_addr = a;
    #1 chk(reg_rdata, exp, tag);
    cyc();
  endtask

  task automatic wrx(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] alist [10];
    void'($urandom(32'h5EED1234));
    alist = '{'h100, 'h104, 'h108, 'h10C, 'h188, 'h190, 'h194, 'h0FC, 'h18C, 'h000};
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(32'(irq), 0, "R1 irq after reset");
    rdx('h100, 32'h0, "R1 status reset");
    rdx('h104, 32'hFFF, "R1 mask reset");
    rdx('h188, 32'h0, "R1 byte counter reset");
    rdx('h190, 32'h0, "R1 src acct reset");
    rdx('h194, 32'h0, "R1 dst acct reset");
    // R2 event capture, masked
    ev_xfer_done = 1; ev_ddesc_done = 1; cyc();
    rdx('h100, 32'h404, "R2 done bits sticky");
    chk(32'(irq), 0, "R6 irq low while masked");
    // R5 unmask
    wrx('h108, 32'h400);
    rdx('h104, 32'hBFF, "R5 unmask clears bit 10");
    chk(32'(irq), 1, "R6 irq high when unmasked");
    wrx('h104, 32'h0);
    rdx('h104, 32'hBFF, "R5 write to mask offset ignored");
    // R3 write-one clear
    wrx('h100, 32'h000);
    rdx('h100, 32'h404, "R3 zero write keeps status");
    wrx('h100, 32'h400);
    rdx('h100, 32'h004, "R3 clear bit 10 only");
    chk(32'(irq), 0, "R6 irq drops after clear");
    // R4 event vs clear
    ev_xfer_done = 1; reg_wr = 1; reg_addr = 'h100; reg_wdata = 32'h400; cyc();
    rdx('h100, 32'h404, "R4 event wins over clear");
    wrx('h10C, 32'hFFF);
    rdx('h104, 32'hFFF, "R5 mask all");
    chk(32'(irq), 0, "R6 irq low when all masked");
    wrx('h100, 32'hFFF);
    rdx('h100, 32'h0, "R3 clear all");
    // R7 accounting
    repeat (3) begin dst_acct_inc = 1; cyc(); end
    rdx('h194, 32'h3, "R7 dst acct count");
    rdx('h194, 32'h0, "R7 dst acct cleared by read");
    src_acct_inc = 1; cyc();
    src_acct_inc = 1; reg_rd = 1; reg_addr = 'h190;
    #1 chk(reg_rdata, 32'h1, "R7 read with increment returns old");
    cyc();
    rdx('h190, 32'h1, "R7 increment during read leaves 1");
    // R8 saturation
    repeat (8) begin src_acct_inc = 1; cyc(); end
    rdx('h190, 32'h7, "R8 src acct saturated");
    rdx('h100, 32'h010, "R8 src acct error bit 4");
    wrx('h100, 32'hFFF);
    // R9 / R10 byte counter
    wrx('h188, 32'h0);
    repeat (3) begin beat_vld = 1; beat_bytes = 6'h3F; cyc(); end
    rdx('h188, 32'hBD, "R9 byte sum");
    beat_vld = 1; beat_bytes = 6'h3F; cyc();
    rdx('h100, 32'h0, "R10 no overflow before wrap");
    beat_vld = 1; beat_bytes = 6'h05; cyc();
    rdx('h188, 32'h01, "R10 wrapped value");
    rdx('h100, 32'h008, "R10 overflow bit 3");
    beat_vld = 1; beat_bytes = 6'h3F; reg_wr = 1; reg_addr = 'h188; reg_wdata = 32'h0; cyc();
    rdx('h188, 32'h0, "R9 write zero restarts, beats priority lost");
    wrx('h100, 32'hFFF);
    // R11 unmapped
    rdx('h0FC, 32'h0, "R11 unmapped read is 0");
    rdx('h108, 32'h0, "R11 enable port reads 0");
    rdx('h100, 32'h001, "R11 invalid access bit 0");
    wrx('h1A0, 32'hFFFF_FFFF);
    rdx('h104, 32'hFFF, "R11 unmapped write leaves mask");
    wrx('h100, 32'h001);
    // R2 bits 1 and 11 never set
    wrx('h108, 32'hFFF);
    ev_wdata_err = 1; ev_rdata_err = 1; ev_ddesc_err = 1; ev_sdesc_err = 1; cyc();
    rdx('h100, 32'h3C0, "R2 error bits, bits 1 and 11 zero");
    chk(32'(irq), 1, "R6 irq on errors");
    wrx('h100, 32'hFFF);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      ev_xfer_done = ($urandom % 8) == 0; ev_wdata_err = ($urandom % 16) == 0;
      ev_rdata_err = ($urandom % 16) == 0; ev_ddesc_err = ($urandom % 16) == 0;
      ev_sdesc_err = ($urandom % 16) == 0; ev_ddesc_done = ($urandom % 8) == 0;
      src_acct_inc = ($urandom % 3) == 0; dst_acct_inc = ($urandom % 3) == 0;
      beat_vld = ($urandom % 2) == 0; beat_bytes = BEAT_W'($urandom);
      op = $urandom % 4;
      reg_addr = alist[$urandom % 10];
      reg_wdata = (reg_addr == 'h188) ? 32'($urandom % 256) : 32'($urandom % 4096);
      reg_rd = op == 1 || op == 2;
      reg_wr = op == 3;
      cyc();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule